// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing half of a 256-byte two-wire serial memory. It watches an oversampled, already synchronised clock line and data line, recognises start and stop conditions, shifts bytes in and out MSB first, and drives an open-drain enable that pulls the data line low for acknowledges and for read data. It checks the device address byte against a fixed type code and a three-bit strap. It also keeps the word address counter, which holds its value between transactions.

Write data is not stored here. Each completed data byte is handed to a separate page and commit engine as a one-cycle request that carries the word address and the data. While that engine reports busy, the block withholds its acknowledge on every device address, so a master can poll until the write has finished. Reads fetch bytes combinationally from the memory array through a read address port.

Top module: `twi_eeprom_slave`

## Requirements
- R1: Out of reset `sda_oe_o` and `wr_req_o` are low. A start condition (data falling while the clock is high) begins the address phase from any state. A stop condition (data rising while the clock is high) returns the block to idle and releases the data line on the next cycle.
- R2: The device address byte is sent MSB first. Bits 7:4 must equal 4'b1010, bits 3:1 must equal `strap_i`, and bit 0 selects the operation (1 = read, 0 = write). On a match the block holds `sda_oe_o` high through the ninth clock.
- R3: On an address mismatch the block gives no acknowledge and drives nothing until the next start condition.
- R4: While `wr_busy_i` is high, even a matching device address is not acknowledged. Once `wr_busy_i` is low, the same address is acknowledged again.
- R5: In a write, the byte after the device address is the word address. It is acknowledged and loads the address counter. Each following data byte is acknowledged and produces a `wr_req_o` pulse one cycle wide, carrying the counter value on `wr_addr_o` and the byte on `wr_data_o`.
- R6: During writes the counter advances only in its low three bits and wraps inside an 8-byte page. The upper five bits never change.
- R7: A read that is not preceded by a word address returns the byte at the counter. The counter persists across transactions, so after a write of address A the next such read returns A+1 within the page.
- R8: A write carrying only a word address, followed by a repeated start and a read, returns the byte at that word address.
- R9: A read continues with the next byte for as long as the master acknowledges. During reads the counter runs across the whole array, wrapping from 255 to 0.
- R10: When the master does not acknowledge a read byte, the block releases the data line and drives nothing more until the next start.
- R11: A start or stop condition inside a byte aborts that byte. A partly shifted data byte never produces `wr_req_o`, and a new address phase after the abort works normally.
- R12: `sda_oe_o` changes only after clock falling edges or on a start or stop condition. It never changes while the clock stays high and the data line is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (wired level) |
| strap_i | input | 3 | Device select strap compared with address bits 3:1 |
| wr_busy_i | input | 1 | Commit engine busy; withholds address acknowledge |
| mem_rdata_i | input | 8 | Memory byte at `mem_raddr_o` |
| sda_oe_o | output | 1 | Pull data line low when high |
| mem_raddr_o | output | 8 | Current word address counter |
| wr_req_o | output | 1 | One-cycle write request to the commit engine |
| wr_addr_o | output | 8 | Word address of the write request |
| wr_data_o | output | 8 | Data byte of the write request |

## Verification
The hardest situation to reach is a bus condition that lands in the middle of a byte. The block must discard a half-shifted data byte and yet keep the word address that was already loaded. Only a master that breaks the usual bit rhythm can bring it about. The stimulus clocks four bits of a data byte and then issues a stop. It then reads without a word address, to show that the counter kept the loaded value and that no write request left the block. A second case cuts the device address short with a repeated start. Wrap-around of the read counter at the top of the array and inside-page wrap of the write counter are reached with a dummy write to addresses 0xFE and 0x1E.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } twi_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned STRAP_W = 3;
endpackage

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int unsigned AW     = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_page_i,
  input  logic          inc_full_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0]     addr_q;
  logic [PAGE_W-1:0] low_next;

  assign low_next = addr_q[PAGE_W-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (load_i)     addr_q <= load_val_i;
    else if (inc_page_i) addr_q <= {addr_q[AW-1:PAGE_W], low_next};
    else if (inc_full_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic                wr_busy_i,
  input  logic [BYTE_W-1:0]   mem_rdata_i,
  output logic                sda_oe_o,
  output logic [AW-1:0]       mem_raddr_o,
  output logic                wr_req_o,
  output logic [AW-1:0]       wr_addr_o,
  output logic [BYTE_W-1:0]   wr_data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  twi_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              m_ack_q;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic              byte_end, addr_match, ld_addr, inc_page, inc_full;
  logic [AW-1:0]     addr;

  twi_bus_events u_events (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  // a whole byte has been shifted in and the ninth clock is about to start
  assign byte_end   = scl_fall && (bit_cnt_q == CNT_FULL);
  assign addr_match = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:1] == strap_i);
  assign ld_addr    = (state_q == ST_WADDR) && byte_end;
  assign inc_page   = (state_q == ST_WDATA) && byte_end;
  assign inc_full   = (state_q == ST_RDATA) && scl_fall && (bit_cnt_q == CNT_LAST);

  twi_addr_ctr #(.AW(AW), .PAGE_W(PAGE_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(ld_addr), .load_val_i(rx_q[AW-1:0]),
    .inc_page_i(inc_page), .inc_full_i(inc_full),
    .addr_o(addr)
  );

  assign mem_raddr_o = addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      m_ack_q   <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_req_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_req_o <= 1'b0;
      if (start_c) begin
        state_q   <= ST_DEV;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_c) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              rx_q      <= {rx_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_end) begin
              bit_cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (addr_match && !wr_busy_i) begin
                  state_q  <= ST_DEV_ACK;
                  sda_oe_o <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADDR) begin
                state_q  <= ST_WADDR_ACK;
                sda_oe_o <= 1'b1;
              end else begin
                state_q   <= ST_WDATA_ACK;
                sda_oe_o  <= 1'b1;
                wr_req_o  <= 1'b1;
                wr_addr_o <= addr;
                wr_data_o <= rx_q;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (rx_q[0]) begin
                state_q  <= ST_RDATA;
                tx_q     <= mem_rdata_i;
                sda_oe_o <= ~mem_rdata_i[BYTE_W-1];
              end else begin
                state_q  <= ST_WADDR;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              state_q  <= ST_WDATA;
              sda_oe_o <= 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt_q == CNT_LAST) begin
                state_q   <= ST_RACK;
                bit_cnt_q <= '0;
                sda_oe_o  <= 1'b0;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe_o  <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              m_ack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (m_ack_q) begin
                state_q  <= ST_RDATA;
                tx_q     <= mem_rdata_i;
                sda_oe_o <= ~mem_rdata_i[BYTE_W-1];
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker #(
  parameter int unsigned AW     = 8,
  parameter int unsigned PAGE_W = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe_o,
  input logic          wr_req_o,
  input logic [AW-1:0] wr_addr_o
);
  logic [1:0]        age_q;
  logic              scl_d, sda_d, seq_q;
  logic [AW-1:0]     last_wa_q;
  logic              stop_seen, start_seen;
  logic [AW-1:0]     exp_next;
  logic [PAGE_W-1:0] exp_low;

  assign stop_seen  = scl_i && scl_d && !sda_d && sda_i;
  assign start_seen = scl_i && scl_d && sda_d && !sda_i;
  assign exp_low    = last_wa_q[PAGE_W-1:0] + 1'b1;
  assign exp_next   = {last_wa_q[AW-1:PAGE_W], exp_low};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q     <= '0;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      seq_q     <= 1'b0;
      last_wa_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 1'b1;
      scl_d <= scl_i;
      sda_d <= sda_i;
      if (start_seen) seq_q <= 1'b0;
      else if (wr_req_o) begin
        seq_q     <= 1'b1;
        last_wa_q <= wr_addr_o;
      end
    end
  end

  assert_stop_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && stop_seen) |=> !sda_oe_o);

  assert_wr_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o);

  assert_page_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && seq_q) |-> (wr_addr_o == exp_next));

  assert_oe_steady_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && scl_i && scl_d && (sda_i == sda_d)) |=> $stable(sda_oe_o));
endmodule

bind twi_eeprom_slave twi_eeprom_checker #(.AW(AW), .PAGE_W(PAGE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe_o(sda_oe_o), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o)
);

// File: tb/twi_eeprom_slave_bench.sv
`timescale 1ns/1ps
module twi_eeprom_slave_bench;
  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_line, sda_oe, wr_req;
  logic [7:0] raddr, rdata, wr_addr, wr_data;
  logic [7:0] mem [256];
  logic [7:0] cap_addr [16];
  logic [7:0] cap_data [16];
  int cap_n = 0;
  int n_checks = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign rdata = mem[raddr];

  twi_eeprom_slave u_twi_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .wr_busy_i(busy), .mem_rdata_i(rdata),
    .sda_oe_o(sda_oe), .mem_raddr_o(raddr), .wr_req_o(wr_req),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  // commit engine and memory model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (wr_req) begin
      mem[wr_addr] <= wr_data;
      cap_addr[cap_n[3:0]] <= wr_addr;
      cap_data[cap_n[3:0]] <= wr_data;
      cap_n <= cap_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl = 1'b0;   wait_clk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(H);
    scl = 1'b1;   wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_m = b[i]; wait_clk(H);
      scl = 1'b1;   wait_clk(H);
      scl = 1'b0;
    end
    wait_clk(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wait_clk(H);
    scl = 1'b1;   wait_clk(H / 2);
    ack = ~sda_line;
    wait_clk(H / 2);
    scl = 1'b0;   wait_clk(2);
  endtask

  task automatic recv_byte(input logic ack_m, output logic [7:0] b, output logic steady);
    sda_m = 1'b1; steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H);
      scl = 1'b1; wait_clk(1);
      b[i] = sda_line;
      wait_clk(H - 2);
      if (sda_line !== b[i]) steady = 1'b0;
      wait_clk(1);
      scl = 1'b0;
    end
    wait_clk(2);
    sda_m = ~ack_m; wait_clk(H);
    scl = 1'b1;     wait_clk(H);
    scl = 1'b0;     wait_clk(2);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 reset sda_oe", 32'(sda_oe), 0);
    check("R1 reset wr_req", 32'(wr_req), 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b0}, ack);
    check("R3 strap mismatch nack", 32'(ack), 0);
    send_byte(8'h00, ack);
    check("R3 silent after mismatch", 32'(ack), 0);
    bus_stop();
    bus_start();
    send_byte({4'b0010, STRAP, 1'b0}, ack);
    check("R2 type code mismatch nack", 32'(ack), 0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    logic ack_d, ack_a, ack_w;
    int n0;
    n0 = cap_n;
    bus_start();
    send_byte(DEV_W, ack_d);
    send_byte(8'h10, ack_a);
    send_byte(8'h3C, ack_w);
    bus_stop();
    check("R2 device address ack", 32'(ack_d), 1);
    check("R5 word address ack", 32'(ack_a), 1);
    check("R5 data ack", 32'(ack_w), 1);
    check("R5 one request", 32'(cap_n - n0), 1);
    check("R5 request addr", 32'(cap_addr[n0[3:0]]), 32'h10);
    check("R5 request data", 32'(cap_data[n0[3:0]]), 32'h3C);
  endtask

  task automatic t_current_read(input logic [7:0] exp, input string req);
    logic ack, st;
    logic [7:0] b;
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, b, st);
    bus_stop();
    check(req, 32'(b), 32'(exp));
    check("R12 read bit steady while SCL high", 32'(st), 1);
  endtask

  task automatic t_page_write();
    logic ack;
    int n0;
    n0 = cap_n;
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h1E, ack);
    for (int k = 0; k < 4; k++) send_byte(8'hD0 + 8'(k), ack);
    bus_stop();
    check("R6 request count", 32'(cap_n - n0), 4);
    check("R6 addr 1", 32'(cap_addr[4'(n0 + 1)]), 32'h1F);
    check("R6 addr wrap in page", 32'(cap_addr[4'(n0 + 2)]), 32'h18);
    check("R6 addr after wrap", 32'(cap_addr[4'(n0 + 3)]), 32'h19);
    check("R6 data after wrap", 32'(cap_data[4'(n0 + 3)]), 32'hD3);
  endtask

  task automatic t_random_and_seq();
    logic ack, st;
    logic [7:0] b0, b1, b2;
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(DEV_R, ack);
    check("R8 read address ack after repeated start", 32'(ack), 1);
    recv_byte(1'b1, b0, st);
    recv_byte(1'b1, b1, st);
    recv_byte(1'b0, b2, st);
    bus_stop();
    check("R8 random read byte", 32'(b0), 32'(mem[8'hFE]));
    check("R9 sequential next byte", 32'(b1), 32'(mem[8'hFF]));
    check("R9 wrap 255 to 0", 32'(b2), 32'(mem[8'h00]));
  endtask

  task automatic t_nack_end();
    logic ack, st;
    logic [7:0] b;
    int lows;
    lows = 0;
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, b, st);
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      wait_clk(H); scl = 1'b1; wait_clk(H / 2);
      if (!sda_line) lows++;
      wait_clk(H / 2); scl = 1'b0;
    end
    wait_clk(2);
    bus_stop();
    check("R10 no drive after master nack", 32'(lows), 0);
  endtask

  task automatic t_busy();
    logic ack;
    busy = 1'b1;
    bus_start();
    send_byte(DEV_W, ack);
    bus_stop();
    check("R4 no ack while busy", 32'(ack), 0);
    busy = 1'b0;
    bus_start();
    send_byte(DEV_W, ack);
    bus_stop();
    check("R4 ack once idle", 32'(ack), 1);
  endtask

  task automatic t_abort();
    logic ack;
    int n0;
    n0 = cap_n;
    bus_start();
    send_byte(DEV_W, ack);
    send_byte(8'h50, ack);
    send_bits(8'hFF, 4);
    bus_stop();
    check("R11 no request for partial byte", 32'(cap_n - n0), 0);
    t_current_read(mem[8'h50], "R11 counter kept after abort");
    bus_start();
    send_bits(DEV_R, 3);
    bus_start();
    send_byte(DEV_R, ack);
    check("R11 address after mid-byte start", 32'(ack), 1);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    t_reset();
    wait_clk(2);
    rst_n = 1'b1;
    wait_clk(4);
    t_mismatch();
    t_byte_write();
    t_current_read(8'h11 ^ 8'h5A, "R7 current read after write");
    t_page_write();
    t_current_read(8'h1A ^ 8'h5A, "R7 counter persists after page write");
    t_random_and_seq();
    t_current_read(mem[8'h01], "R7 counter after sequential read");
    t_nack_end();
    t_busy();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule